// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the host-facing register file of one legacy ATA channel with two drive slots. The host performs single-byte reads and writes. A chip-select bit picks either the eight-entry command block or the control block, and a 3-bit offset picks the register inside it. The channel holds one copy each of status, error, drive/head, features, command and device-control. Each slot has its own copy of sector count, sector number and the two cylinder bytes, and the drive-select bit routes accesses to one of these copies. Two static inputs tell the block whether each slot is populated and whether its device is a packet (ATAPI-style) device.

The controller runs soft-reset on the edges of the reset bit in device control. It enforces the fixed bits of drive/head and reports the selection of an empty slot. When the selected slot is absent, reads return fixed patterns. The block accepts the packet and identify-packet commands and sends every other command code down a common abort path. Interrupt requests are held as a pending level. That level is masked by the interrupt-disable bit and is cleared when the host reads the primary status offset. Data-port transfers, bus-master DMA and the media side are handled elsewhere. The only thing this block exposes to that logic is the byte count of an armed packet phase.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, device control is 0x08, error 0x01, status 0x00 and drive/head 0x00. The pending interrupt is clear. Each slot holds sector count 1, sector number 1 and cylinder bytes 0.
- R2: A device-control write (control block, offset 6) whose bit 2 goes from 0 to 1 makes status 0x90 and error 0x01. It also clears the command register, the pending interrupt and the packet phase, and stores the control value with bit 1 (interrupt disable) forced to 0. A write that leaves bit 2 unchanged has no reset effect.
- R3: A device-control write whose bit 2 goes from 1 to 0 clears status bit 7 (busy), sets status bit 6 (ready) and zeroes drive/head bits 3:0. It then reloads both slots with sector count 1, sector number 1 and cylinder 0xEB14 (high byte 0xEB) for a present packet device, or cylinder 0x0000 for any other slot.
- R4: A write to drive/head (command block, offset 6) is stored ORed with 0xA0, and bit 4 selects the slot. If the newly selected slot is empty, error bit 2 (abort) and status bit 0 (error) are set.
- R5: While the selected slot is absent, a command-block read of offset 6 returns 0xA0 and a read of any other command-block offset returns 0x00.
- R6: A command-block read of offset 1 returns the error register, and a write to that offset stores the features register. Reads of command offset 7 and control offset 6 both return status. A read of control offset 7 always returns 0xFF.
- R7: The irq output is high only while the pending interrupt is set and device-control bit 1 is 0.
- R8: A command-block read of offset 7 clears the pending interrupt. A read of control offset 6 does not.
- R9: Command 0xA0 to a present packet device sets that slot's sector count to 1. It clears status bits 7, 5 and 0, sets status bit 3 (data request) and makes pkt_bytes equal PKT_BYTES. It does not request an interrupt.
- R10: Command 0xA0 to a slot that is not a present packet device, and any code other than 0xA0 or 0xA1, aborts: status 0x41, error 0x04, pending interrupt set, and pkt_bytes 0.
- R11: Command 0xA1 makes error 0x00 and status 0x58, and sets the pending interrupt.
- R12: Sector count, sector number and both cylinder bytes are kept separately for each slot. A write changes only the copy of the selected slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_ctrl | input | 1 | 0 selects the command block, 1 the control block |
| addr | input | 3 | Register offset within the selected block |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (used for side effects only) |
| wdata | input | 8 | Write data |
| slot_present | input | 2 | Per-slot populated flag (static) |
| slot_packet | input | 2 | Per-slot packet-device flag (static) |
| rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt request level |
| pkt_bytes | output | CNT_W | Armed packet-phase byte count, 0 when idle |

## Verification
The bench builds the block with its default parameters. PKT_BYTES is 12, so the armed count is visible as 12 on pkt_bytes, and the reset signature is 0xEB14, so the cylinder bytes of a packet slot read 0xEB and 0x14 after a soft reset. The bench sets slot 0 as a packet device and slot 1 as a plain disk. That makes both signature variants and both outcomes of command 0xA0 reachable from one reset. Later the bench withdraws slot 1 to reach the absent-drive read patterns and the empty-selection flags.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    typedef logic [7:0] byte_t;

    // command-block offsets
    localparam logic [2:0] OFS_ERRFEAT = 3'd1;
    localparam logic [2:0] OFS_SCNT    = 3'd2;
    localparam logic [2:0] OFS_SNUM    = 3'd3;
    localparam logic [2:0] OFS_CYLLO   = 3'd4;
    localparam logic [2:0] OFS_CYLHI   = 3'd5;
    localparam logic [2:0] OFS_DEVHEAD = 3'd6;
    localparam logic [2:0] OFS_CMDSTAT = 3'd7;
    // control-block offsets
    localparam logic [2:0] OFS_DEVCTL  = 3'd6;
    localparam logic [2:0] OFS_DRVADDR = 3'd7;

    // bit positions
    localparam int ST_BSY   = 7;
    localparam int ST_DRDY  = 6;
    localparam int ST_DF    = 5;
    localparam int ST_DRQ   = 3;
    localparam int ST_ERR   = 0;
    localparam int ER_ABRT  = 2;
    localparam int CTL_SRST = 2;
    localparam int CTL_NIEN = 1;
    localparam int DH_SEL   = 4;

    localparam byte_t CMD_PACKET = 8'hA0;
    localparam byte_t CMD_IDPKT  = 8'hA1;

    localparam byte_t ST_AT_SRST  = 8'h90;
    localparam byte_t ST_ABORTED  = 8'h41;
    localparam byte_t ST_IDPKT    = 8'h58;
    localparam byte_t ER_DIAG_OK  = 8'h01;
    localparam byte_t ER_ABORTED  = 8'h04;
    localparam byte_t DH_FIXED    = 8'hA0;

    typedef struct packed {
        byte_t scnt;
        byte_t snum;
        byte_t cyl_lo;
        byte_t cyl_hi;
    } addr_regs_t;

    typedef struct packed {
        logic scnt;
        logic snum;
        logic cyl_lo;
        logic cyl_hi;
    } addr_wr_t;

    function automatic byte_t fix_devhead(byte_t v);
        return v | DH_FIXED;
    endfunction

endpackage

// File: rtl/atf_addr_bank.sv
module atf_addr_bank
    import ata_tf_pkg::*;
#(
    parameter logic [15:0] SIG_CYL = 16'hEB14
) (
    input  logic       clk,
    input  logic       rst,
    input  addr_wr_t   wr,
    input  byte_t      wdata,
    input  logic       scnt_one,
    input  logic       sig_load,
    input  logic       is_packet,
    output addr_regs_t regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '{scnt: 8'd1, snum: 8'd1, cyl_lo: 8'd0, cyl_hi: 8'd0};
        end else if (sig_load) begin
            regs.scnt   <= 8'd1;
            regs.snum   <= 8'd1;
            regs.cyl_lo <= is_packet ? SIG_CYL[7:0]  : 8'd0;
            regs.cyl_hi <= is_packet ? SIG_CYL[15:8] : 8'd0;
        end else begin
            if (wr.scnt)   regs.scnt   <= wdata;
            if (wr.snum)   regs.snum   <= wdata;
            if (wr.cyl_lo) regs.cyl_lo <= wdata;
            if (wr.cyl_hi) regs.cyl_hi <= wdata;
            if (scnt_one)  regs.scnt   <= 8'd1;
        end
    end
endmodule

// File: rtl/atf_rd_mux.sv
module atf_rd_mux
    import ata_tf_pkg::*;
(
    input  logic       cs_ctrl,
    input  logic [2:0] addr,
    input  logic       sel_present,
    input  byte_t      status,
    input  byte_t      error,
    input  byte_t      devhead,
    input  addr_regs_t sel_regs,
    output byte_t      rdata
);
    always_comb begin
        rdata = 8'h00;
        if (cs_ctrl) begin
            if (addr == OFS_DRVADDR)     rdata = 8'hFF;
            else if (addr == OFS_DEVCTL) rdata = status;
        end else if (!sel_present) begin
            if (addr == OFS_DEVHEAD) rdata = DH_FIXED;
        end else begin
            unique case (addr)
                OFS_ERRFEAT: rdata = error;
                OFS_SCNT:    rdata = sel_regs.scnt;
                OFS_SNUM:    rdata = sel_regs.snum;
                OFS_CYLLO:   rdata = sel_regs.cyl_lo;
                OFS_CYLHI:   rdata = sel_regs.cyl_hi;
                OFS_DEVHEAD: rdata = devhead;
                OFS_CMDSTAT: rdata = status;
                default:     rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter int          PKT_BYTES = 12,
    parameter logic [15:0] SIG_CYL   = 16'hEB14,
    localparam int         CNT_W     = $clog2(PKT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_ctrl,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    input  logic [1:0]       slot_present,
    input  logic [1:0]       slot_packet,
    output logic [7:0]       rdata,
    output logic             irq,
    output logic [CNT_W-1:0] pkt_bytes
);
    localparam int NSLOT = 2;

    byte_t status_q, error_q, devhead_q, feat_q, cmd_q, ctrl_q;
    logic  irq_pend_q, pkt_arm_q;
    addr_regs_t bank [NSLOT];

    logic sel, cmd_wr, ctl_wr, srst_rise, srst_fall;
    logic cmd_go, pkt_ok, id_go, abort_go, stat_rd;

    assign sel       = devhead_q[DH_SEL];
    assign cmd_wr    = wr_en && !cs_ctrl;
    assign ctl_wr    = wr_en && cs_ctrl && (addr == OFS_DEVCTL);
    assign srst_rise = ctl_wr &&  wdata[CTL_SRST] && !ctrl_q[CTL_SRST];
    assign srst_fall = ctl_wr && !wdata[CTL_SRST] &&  ctrl_q[CTL_SRST];
    assign cmd_go    = cmd_wr && (addr == OFS_CMDSTAT);
    assign pkt_ok    = cmd_go && (wdata == CMD_PACKET) && slot_present[sel] && slot_packet[sel];
    assign id_go     = cmd_go && (wdata == CMD_IDPKT);
    assign abort_go  = cmd_go && !pkt_ok && !id_go;
    assign stat_rd   = rd_en && !cs_ctrl && (addr == OFS_CMDSTAT);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        addr_wr_t wr_g;
        logic     hit;
        assign hit          = cmd_wr && (sel == g[0]);
        assign wr_g.scnt    = hit && (addr == OFS_SCNT);
        assign wr_g.snum    = hit && (addr == OFS_SNUM);
        assign wr_g.cyl_lo  = hit && (addr == OFS_CYLLO);
        assign wr_g.cyl_hi  = hit && (addr == OFS_CYLHI);

        atf_addr_bank #(.SIG_CYL(SIG_CYL)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr        (wr_g),
            .wdata     (wdata),
            .scnt_one  (pkt_ok && (sel == g[0])),
            .sig_load  (srst_fall),
            .is_packet (slot_present[g] && slot_packet[g]),
            .regs      (bank[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= 8'h08;
            error_q    <= ER_DIAG_OK;
            status_q   <= 8'h00;
            devhead_q  <= 8'h00;
            feat_q     <= 8'h00;
            cmd_q      <= 8'h00;
            irq_pend_q <= 1'b0;
            pkt_arm_q  <= 1'b0;
        end else begin
            if (stat_rd) irq_pend_q <= 1'b0;

            if (ctl_wr) begin
                ctrl_q <= wdata;
                if (srst_rise) ctrl_q[CTL_NIEN] <= 1'b0;
            end

            if (srst_rise) begin
                status_q   <= ST_AT_SRST;
                error_q    <= ER_DIAG_OK;
                cmd_q      <= 8'h00;
                irq_pend_q <= 1'b0;
                pkt_arm_q  <= 1'b0;
            end else if (srst_fall) begin
                status_q[ST_BSY]  <= 1'b0;
                status_q[ST_DRDY] <= 1'b1;
                devhead_q[3:0]    <= 4'h0;
            end

            if (cmd_wr && addr == OFS_ERRFEAT) feat_q <= wdata;

            if (cmd_wr && addr == OFS_DEVHEAD) begin
                devhead_q <= fix_devhead(wdata);
                if (!slot_present[wdata[DH_SEL]]) begin
                    error_q[ER_ABRT] <= 1'b1;
                    status_q[ST_ERR] <= 1'b1;
                end
            end

            if (cmd_go) begin
                cmd_q <= wdata;
                if (pkt_ok) begin
                    status_q[ST_BSY] <= 1'b0;
                    status_q[ST_DF]  <= 1'b0;
                    status_q[ST_ERR] <= 1'b0;
                    status_q[ST_DRQ] <= 1'b1;
                    pkt_arm_q        <= 1'b1;
                end else if (id_go) begin
                    error_q    <= 8'h00;
                    status_q   <= ST_IDPKT;
                    irq_pend_q <= 1'b1;
                    pkt_arm_q  <= 1'b0;
                end else if (abort_go) begin
                    status_q   <= ST_ABORTED;
                    error_q    <= ER_ABORTED;
                    irq_pend_q <= 1'b1;
                    pkt_arm_q  <= 1'b0;
                end
            end
        end
    end

    atf_rd_mux u_rd (
        .cs_ctrl     (cs_ctrl),
        .addr        (addr),
        .sel_present (slot_present[sel]),
        .status      (status_q),
        .error       (error_q),
        .devhead     (devhead_q),
        .sel_regs    (bank[sel]),
        .rdata       (rdata)
    );

    assign irq       = irq_pend_q && !ctrl_q[CTL_NIEN];
    assign pkt_bytes = pkt_arm_q ? CNT_W'(PKT_BYTES) : '0;

endmodule

// File: rtl/atf_chk.sv
module atf_chk
    import ata_tf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_ctrl,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       irq,
    input logic [7:0] status_q,
    input logic [7:0] ctrl_q,
    input logic [7:0] cmd_q,
    input logic [7:0] feat_q,
    input logic [7:0] devhead_q
);
    // R2
    srst_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cs_ctrl && addr == OFS_DEVCTL && wdata[CTL_SRST] && !ctrl_q[CTL_SRST])
        |=> (status_q == ST_AT_SRST && cmd_q == 8'h00 && !ctrl_q[CTL_NIEN] && !irq));

    // R4
    devhead_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cs_ctrl && addr == OFS_DEVHEAD) |=> (devhead_q[7] && devhead_q[5]));

    // R6
    drvaddr_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_ctrl && addr == OFS_DRVADDR) |-> (rdata == 8'hFF));

    // R6
    feat_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cs_ctrl && addr == OFS_ERRFEAT) |=> (feat_q == $past(wdata)));

    // R7
    nien_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cs_ctrl && addr == OFS_DEVCTL && wdata[CTL_NIEN]
         && !(wdata[CTL_SRST] && !ctrl_q[CTL_SRST])) |=> !irq);

    // R10
    unsup_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cs_ctrl && addr == OFS_CMDSTAT && wdata != CMD_PACKET && wdata != CMD_IDPKT)
        |=> (status_q == ST_ABORTED));
endmodule

bind ata_taskfile_ctrl atf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_ctrl   (cs_ctrl),
    .addr      (addr),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq       (irq),
    .status_q  (status_q),
    .ctrl_q    (ctrl_q),
    .cmd_q     (cmd_q),
    .feat_q    (feat_q),
    .devhead_q (devhead_q)
);

// File: tb/ata_taskfile_ctrl_test.sv
module ata_taskfile_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_ctrl = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [1:0] slot_present = 2'b11;
    logic [1:0] slot_packet = 2'b01;
    logic [7:0] rdata;
    logic       irq;
    logic [3:0] pkt_bytes;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ata_taskfile_ctrl uut (
        .clk(clk), .rst(rst), .cs_ctrl(cs_ctrl), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .slot_present(slot_present),
        .slot_packet(slot_packet), .rdata(rdata), .irq(irq), .pkt_bytes(pkt_bytes)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic cs, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_ctrl = cs; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // read with strobe; compare rdata before the strobing edge
    task automatic rd(input logic cs, input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs_ctrl = cs; addr = a; rd_en = 1'b1;
        #1 check(tag, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset_state;
        rd(1, 3'd6, 8'h00, "R1 status");
        rd(0, 3'd1, 8'h01, "R1 error");
        rd(0, 3'd6, 8'h00, "R1 devhead");
        rd(0, 3'd2, 8'h01, "R1 scnt");
        rd(0, 3'd3, 8'h01, "R1 snum");
        rd(0, 3'd4, 8'h00, "R1 cyl_lo");
        rd(0, 3'd5, 8'h00, "R1 cyl_hi");
        check("R1 irq", irq, 0);
        check("R1 pkt", pkt_bytes, 0);
    endtask

    task automatic t_per_slot;
        wr(0, 3'd2, 8'h33);
        wr(0, 3'd6, 8'h10);
        rd(0, 3'd6, 8'hB0, "R4 devhead or");
        rd(0, 3'd2, 8'h01, "R12 slot1 untouched");
        wr(0, 3'd2, 8'h44);
        rd(0, 3'd2, 8'h44, "R12 slot1 scnt");
        wr(0, 3'd6, 8'h00);
        rd(0, 3'd6, 8'hA0, "R4 devhead slot0");
        rd(0, 3'd2, 8'h33, "R12 slot0 scnt");
        rd(1, 3'd7, 8'hFF, "R6 drvaddr");
    endtask

    task automatic t_identify;
        wr(0, 3'd7, 8'hA1);
        rd(1, 3'd6, 8'h58, "R11 status");
        rd(0, 3'd1, 8'h00, "R11 error");
        check("R11 irq", irq, 1);
        rd(1, 3'd6, 8'h58, "R8 altstatus");
        check("R8 irq kept", irq, 1);
        rd(0, 3'd7, 8'h58, "R6 status offset");
        check("R8 irq cleared", irq, 0);
    endtask

    task automatic t_mask;
        wr(1, 3'd6, 8'h02);
        wr(0, 3'd7, 8'h55);
        check("R7 masked", irq, 0);
        rd(1, 3'd6, 8'h41, "R10 status");
        rd(0, 3'd1, 8'h04, "R10 error");
        wr(1, 3'd6, 8'h00);
        check("R7 unmasked", irq, 1);
        rd(0, 3'd7, 8'h41, "R8 read");
        check("R8 cleared", irq, 0);
    endtask

    task automatic t_packet;
        wr(0, 3'd2, 8'h07);
        wr(0, 3'd7, 8'hA0);
        rd(1, 3'd6, 8'h48, "R9 status");
        rd(0, 3'd2, 8'h01, "R9 scnt");
        check("R9 pkt", pkt_bytes, 12);
        check("R9 irq", irq, 0);
        wr(0, 3'd6, 8'h10);
        wr(0, 3'd7, 8'hA0);
        rd(1, 3'd6, 8'h41, "R10 disk status");
        rd(0, 3'd1, 8'h04, "R10 disk error");
        check("R10 pkt", pkt_bytes, 0);
        check("R10 irq", irq, 1);
        rd(0, 3'd7, 8'h41, "R8 clr");
    endtask

    task automatic t_srst;
        wr(0, 3'd3, 8'h22);
        wr(0, 3'd4, 8'h11);
        wr(0, 3'd5, 8'h12);
        wr(0, 3'd6, 8'h00);
        wr(0, 3'd4, 8'h99);
        wr(0, 3'd6, 8'h13);
        wr(1, 3'd6, 8'h06);
        rd(1, 3'd6, 8'h90, "R2 status");
        rd(0, 3'd1, 8'h01, "R2 error");
        wr(0, 3'd7, 8'h55);
        check("R2 nien cleared", irq, 1);
        rd(0, 3'd7, 8'h41, "R8 clr");
        wr(1, 3'd6, 8'h06);
        rd(1, 3'd6, 8'h41, "R2 no edge status");
        rd(0, 3'd1, 8'h04, "R2 no edge error");
        wr(1, 3'd6, 8'h00);
        rd(0, 3'd6, 8'hB0, "R3 head zero");
        rd(0, 3'd3, 8'h01, "R3 disk snum");
        rd(0, 3'd4, 8'h00, "R3 disk cyl_lo");
        rd(0, 3'd5, 8'h00, "R3 disk cyl_hi");
        wr(0, 3'd6, 8'h00);
        rd(0, 3'd4, 8'h14, "R3 pkt cyl_lo");
        rd(0, 3'd5, 8'hEB, "R3 pkt cyl_hi");
        rd(0, 3'd2, 8'h01, "R3 pkt scnt");
        wr(1, 3'd6, 8'h04);
        wr(1, 3'd6, 8'h00);
        rd(1, 3'd6, 8'h50, "R3 status");
    endtask

    task automatic t_absent;
        slot_present = 2'b01;
        wr(0, 3'd6, 8'h10);
        rd(0, 3'd6, 8'hA0, "R5 devhead");
        rd(0, 3'd2, 8'h00, "R5 scnt");
        rd(0, 3'd1, 8'h00, "R5 error");
        rd(0, 3'd7, 8'h00, "R5 status");
        rd(1, 3'd6, 8'h51, "R4 err flag");
        rd(1, 3'd7, 8'hFF, "R6 drvaddr absent");
        wr(0, 3'd6, 8'h00);
        rd(0, 3'd1, 8'h05, "R4 abrt flag");
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_per_slot();
        t_identify();
        t_mask();
        t_packet();
        t_srst();
        t_absent();
        report();
    end
endmodule